// File: doc/BRIEF.md
# Dirty Scanline Run Coalescer

This block turns one frame's worth of per-scanline dirty flags into a short list of refresh rectangles. Scanlines arrive one flag at a time over a valid/ready handshake, in increasing line order from 0 to the frame height minus 1. Each stretch of consecutive dirty lines becomes one rectangle, given as a start line and a line count. Every rectangle begins at column 0 and spans the mode width captured when the frame began. The rectangles leave over a second valid/ready stream.

A frame begins with a start pulse that carries the frame height, the mode width and a whole-screen request flag. When the whole-screen flag is set, the scan is skipped and the block sends a single rectangle covering every line. When the last line has been handled and the last rectangle has been taken downstream, a one-cycle done pulse closes the frame. The output holds one rectangle at a time, so the line input stalls while a rectangle is waiting for downstream acceptance.

Top module: `scan_run_coalescer`

## Requirements
- R1: After reset, rect_valid, frame_done and line_ready are all low.
- R2: frame_start is acted on only while the block is idle. A pulse that arrives during a frame changes neither the frame's rectangles nor its height.
- R3: A dirty line (line_dirty = 1) seen while no run is open opens a run that starts at that line's index. Line indices count accepted lines from 0.
- R4: A clean line (line_dirty = 0) seen while a run is open emits a rectangle with rect_y equal to the run start and rect_count equal to the clean line's index minus the start. That rectangle has a count of at least 1.
- R5: A run that is still open at the last line (index height minus 1) is emitted with rect_count equal to the height minus its start. No rectangle extends past the frame height.
- R6: Every rectangle has rect_x equal to 0 and rect_w equal to the mode_width sampled with the accepted frame_start.
- R7: When full_req is high with an accepted frame_start and the height is non-zero, exactly one rectangle (rect_y 0, rect_count equal to the height) is emitted, and line_ready stays low for the whole frame.
- R8: A frame with no dirty line emits no rectangle and still ends with frame_done.
- R9: While rect_valid is high, line_ready is low. A rectangle that is not accepted keeps the same values until it is accepted.
- R10: frame_done is high for exactly one cycle per frame. It comes after the last rectangle has been accepted, and never while rect_valid is high.
- R11: A frame with height 0 emits no rectangle and ends with frame_done.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| frame_start | input | 1 | Begins a frame when the block is idle |
| frame_height | input | LINE_W | Number of lines in the frame, sampled with frame_start |
| mode_width | input | WIDTH_W | Mode width in pixels, sampled with frame_start |
| full_req | input | 1 | Whole-screen refresh request, sampled with frame_start |
| line_valid | input | 1 | A dirty flag is offered |
| line_dirty | input | 1 | Dirty flag of the current line |
| line_ready | output | 1 | The block takes the offered flag |
| rect_valid | output | 1 | A rectangle is offered |
| rect_ready | input | 1 | Downstream takes the rectangle |
| rect_x | output | WIDTH_W | Left column, always 0 |
| rect_w | output | WIDTH_W | Rectangle width in pixels |
| rect_y | output | LINE_W | First line of the rectangle |
| rect_count | output | LINE_W | Number of lines in the rectangle |
| frame_done | output | 1 | One-cycle end-of-frame pulse |

## Verification
The assertions check the handshake rules on every cycle. They check that a rectangle holds steady under backpressure, that lines stall while a rectangle is pending, that counts are non-zero and stay inside the frame height, and that frame_done is a lone pulse with no rectangle pending. Whether the right runs were merged depends on the flag pattern of a whole frame, so only the bench's scenarios can show it. The same holds for the flush at the last line, the whole-screen bypass, empty frames and the ignored mid-frame start. The scoreboard compares those results against a line-by-line model of each frame.

// File: rtl/scr_pkg.sv
package scr_pkg;

   typedef enum logic [1:0] {
      ST_IDLE  = 2'd0,
      ST_SCAN  = 2'd1,
      ST_DRAIN = 2'd2
   } frame_state_e;

   localparam int MIN_LINE_W  = 2;
   localparam int MAX_LINE_W  = 16;
   localparam int MIN_WIDTH_W = 1;
   localparam int MAX_WIDTH_W = 16;

endpackage

// File: rtl/scr_line_counter.sv
module scr_line_counter #(
   parameter int LINE_W = 12
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              clear,
   input  logic              advance,
   input  logic [LINE_W-1:0] height,
   output logic [LINE_W-1:0] cur,
   output logic              is_last
);

   localparam logic [LINE_W-1:0] ONE = LINE_W'(1);

   logic [LINE_W-1:0] cur_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cur_q <= '0;
      end else if (clear) begin
         cur_q <= '0;
      end else if (advance) begin
         cur_q <= cur_q + ONE;
      end
   end

   assign cur     = cur_q;
   assign is_last = (cur_q == (height - ONE));

endmodule

// File: rtl/scr_run_tracker.sv
module scr_run_tracker #(
   parameter int LINE_W = 12
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              clear,
   input  logic              take,
   input  logic              dirty,
   input  logic [LINE_W-1:0] cur,
   input  logic              is_last,
   input  logic [LINE_W-1:0] height,
   output logic              emit,
   output logic [LINE_W-1:0] emit_y,
   output logic [LINE_W-1:0] emit_cnt
);

   logic              open_q;
   logic [LINE_W-1:0] start_q;
   logic              close_on_clean;
   logic              flush_at_end;

   assign close_on_clean = !dirty && open_q;
   assign flush_at_end   = is_last && (dirty || open_q);
   assign emit           = take && (close_on_clean || flush_at_end);
   assign emit_y         = open_q ? start_q : cur;

   always_comb begin
      if (!dirty) begin
         emit_cnt = cur - start_q;
      end else begin
         emit_cnt = height - emit_y;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         open_q  <= 1'b0;
         start_q <= '0;
      end else if (clear) begin
         open_q  <= 1'b0;
         start_q <= '0;
      end else if (take) begin
         open_q <= dirty && !is_last;
         if (dirty && !open_q) begin
            start_q <= cur;
         end
      end
   end

endmodule

// File: rtl/scr_rect_reg.sv
module scr_rect_reg #(
   parameter int LINE_W = 12
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load,
   input  logic [LINE_W-1:0] in_y,
   input  logic [LINE_W-1:0] in_cnt,
   input  logic              out_ready,
   output logic              out_valid,
   output logic [LINE_W-1:0] out_y,
   output logic [LINE_W-1:0] out_cnt
);

   logic              valid_q;
   logic [LINE_W-1:0] y_q;
   logic [LINE_W-1:0] cnt_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         valid_q <= 1'b0;
         y_q     <= '0;
         cnt_q   <= '0;
      end else if (load) begin
         valid_q <= 1'b1;
         y_q     <= in_y;
         cnt_q   <= in_cnt;
      end else if (valid_q && out_ready) begin
         valid_q <= 1'b0;
      end
   end

   assign out_valid = valid_q;
   assign out_y     = y_q;
   assign out_cnt   = cnt_q;

endmodule

// File: rtl/scan_run_coalescer.sv
module scan_run_coalescer #(
   parameter int LINE_W  = 12,
   parameter int WIDTH_W = 16
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               frame_start,
   input  logic [LINE_W-1:0]  frame_height,
   input  logic [WIDTH_W-1:0] mode_width,
   input  logic               full_req,
   input  logic               line_valid,
   input  logic               line_dirty,
   output logic               line_ready,
   output logic               rect_valid,
   input  logic               rect_ready,
   output logic [WIDTH_W-1:0] rect_x,
   output logic [WIDTH_W-1:0] rect_w,
   output logic [LINE_W-1:0]  rect_y,
   output logic [LINE_W-1:0]  rect_count,
   output logic               frame_done
);
   import scr_pkg::*;

   generate
      if (LINE_W < MIN_LINE_W || LINE_W > MAX_LINE_W) begin : g_bad_line_w
         $error("scan_run_coalescer: LINE_W out of range");
      end
      if (WIDTH_W < MIN_WIDTH_W || WIDTH_W > MAX_WIDTH_W) begin : g_bad_width_w
         $error("scan_run_coalescer: WIDTH_W out of range");
      end
   endgenerate

   frame_state_e       state_q;
   logic [LINE_W-1:0]  height_q;
   logic [WIDTH_W-1:0] width_q;

   logic              start_ok;
   logic              full_load;
   logic              line_take;
   logic [LINE_W-1:0] cur_line;
   logic              last_line;
   logic              run_emit;
   logic [LINE_W-1:0] run_y;
   logic [LINE_W-1:0] run_cnt;
   logic              load;
   logic [LINE_W-1:0] load_y;
   logic [LINE_W-1:0] load_cnt;

   assign start_ok   = frame_start && (state_q == ST_IDLE);
   assign full_load  = start_ok && full_req && (frame_height != '0);
   assign line_ready = (state_q == ST_SCAN) && !rect_valid;
   assign line_take  = line_valid && line_ready;
   assign frame_done = (state_q == ST_DRAIN) && !rect_valid;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q  <= ST_IDLE;
         height_q <= '0;
         width_q  <= '0;
      end else begin
         case (state_q)
            ST_IDLE: begin
               if (start_ok) begin
                  height_q <= frame_height;
                  width_q  <= mode_width;
                  if (frame_height == '0 || full_req) begin
                     state_q <= ST_DRAIN;
                  end else begin
                     state_q <= ST_SCAN;
                  end
               end
            end
            ST_SCAN: begin
               if (line_take && last_line) begin
                  state_q <= ST_DRAIN;
               end
            end
            ST_DRAIN: begin
               if (!rect_valid) begin
                  state_q <= ST_IDLE;
               end
            end
            default: state_q <= ST_IDLE;
         endcase
      end
   end

   scr_line_counter #(.LINE_W(LINE_W)) u_lines (
      .clk     (clk),
      .rst_n   (rst_n),
      .clear   (start_ok),
      .advance (line_take),
      .height  (height_q),
      .cur     (cur_line),
      .is_last (last_line)
   );

   scr_run_tracker #(.LINE_W(LINE_W)) u_runs (
      .clk      (clk),
      .rst_n    (rst_n),
      .clear    (start_ok),
      .take     (line_take),
      .dirty    (line_dirty),
      .cur      (cur_line),
      .is_last  (last_line),
      .height   (height_q),
      .emit     (run_emit),
      .emit_y   (run_y),
      .emit_cnt (run_cnt)
   );

   assign load     = run_emit || full_load;
   assign load_y   = full_load ? '0 : run_y;
   assign load_cnt = full_load ? frame_height : run_cnt;

   scr_rect_reg #(.LINE_W(LINE_W)) u_out (
      .clk       (clk),
      .rst_n     (rst_n),
      .load      (load),
      .in_y      (load_y),
      .in_cnt    (load_cnt),
      .out_ready (rect_ready),
      .out_valid (rect_valid),
      .out_y     (rect_y),
      .out_cnt   (rect_count)
   );

   assign rect_x = '0;
   assign rect_w = width_q;

endmodule

// File: rtl/scan_run_coalescer_checker.sv
module scan_run_coalescer_checker #(
   parameter int LINE_W = 12
) (
   input logic              clk,
   input logic              rst_n,
   input logic              line_ready,
   input logic              rect_valid,
   input logic              rect_ready,
   input logic [LINE_W-1:0] rect_y,
   input logic [LINE_W-1:0] rect_count,
   input logic              frame_done,
   input logic [LINE_W-1:0] height_q
);

   AST_RECT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (rect_valid && !rect_ready) |=> (rect_valid && $stable(rect_y) && $stable(rect_count))); // R9

   AST_STALL_LINES: assert property (@(posedge clk) disable iff (!rst_n)
      rect_valid |-> !line_ready); // R9

   AST_COUNT_NONZERO: assert property (@(posedge clk) disable iff (!rst_n)
      rect_valid |-> (rect_count != '0)); // R4

   AST_INSIDE_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
      rect_valid |-> (({1'b0, rect_y} + {1'b0, rect_count}) <= {1'b0, height_q})); // R5

   AST_DONE_DRAINED: assert property (@(posedge clk) disable iff (!rst_n)
      frame_done |-> !rect_valid); // R10

   AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      frame_done |=> !frame_done); // R10

endmodule

bind scan_run_coalescer scan_run_coalescer_checker #(.LINE_W(LINE_W)) u_checker (
   .clk        (clk),
   .rst_n      (rst_n),
   .line_ready (line_ready),
   .rect_valid (rect_valid),
   .rect_ready (rect_ready),
   .rect_y     (rect_y),
   .rect_count (rect_count),
   .frame_done (frame_done),
   .height_q   (height_q)
);

// File: tb/scan_run_coalescer_test.sv
module scan_run_coalescer_test;

   localparam int LW = 12;
   localparam int WW = 16;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          frame_start = 1'b0;
   logic [LW-1:0] frame_height = '0;
   logic [WW-1:0] mode_width = '0;
   logic          full_req = 1'b0;
   logic          line_valid = 1'b0;
   logic          line_dirty = 1'b0;
   logic          line_ready;
   logic          rect_valid;
   logic          rect_ready = 1'b1;
   logic [WW-1:0] rect_x;
   logic [WW-1:0] rect_w;
   logic [LW-1:0] rect_y;
   logic [LW-1:0] rect_count;
   logic          frame_done;

   int checks = 0;
   int errors = 0;
   bit bp_mode = 1'b0;
   bit in_full = 1'b0;
   logic [15:0] lfsr = 16'hACE1;

   typedef struct packed {
      logic [LW-1:0] y;
      logic [LW-1:0] cnt;
      logic [WW-1:0] w;
   } exp_rect_t;

   exp_rect_t exp_q[$];

   scan_run_coalescer #(.LINE_W(LW), .WIDTH_W(WW)) uut (
      .clk          (clk),
      .rst_n        (rst_n),
      .frame_start  (frame_start),
      .frame_height (frame_height),
      .mode_width   (mode_width),
      .full_req     (full_req),
      .line_valid   (line_valid),
      .line_dirty   (line_dirty),
      .line_ready   (line_ready),
      .rect_valid   (rect_valid),
      .rect_ready   (rect_ready),
      .rect_x       (rect_x),
      .rect_w       (rect_w),
      .rect_y       (rect_y),
      .rect_count   (rect_count),
      .frame_done   (frame_done)
   );

   always #4 clk = ~clk;

   task automatic check(input bit ok, input string req, input string what,
                        input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
      end
   endtask

   // downstream ready pattern
   initial begin
      forever begin
         @(posedge clk);
         #1;
         lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
         rect_ready = bp_mode ? lfsr[0] & lfsr[3] : 1'b1;
      end
   end

   // scoreboard monitor
   initial begin
      exp_rect_t e;
      forever begin
         @(negedge clk);
         if (rst_n && rect_valid && rect_ready) begin
            if (exp_q.size() == 0) begin
               check(1'b0, "R2 R8", "unexpected rectangle y", int'(rect_y), -1);
            end else begin
               e = exp_q.pop_front();
               check(rect_y == e.y, "R3 R4 R5 R7", "rect_y", int'(rect_y), int'(e.y));
               check(rect_count == e.cnt, "R4 R5 R7", "rect_count", int'(rect_count), int'(e.cnt));
               check(rect_w == e.w && rect_x == '0, "R6", "rect_w", int'(rect_w), int'(e.w));
            end
         end
      end
   end

   // backpressure stability and line stall
   initial begin
      logic          held = 1'b0;
      logic [LW-1:0] hy = '0;
      logic [LW-1:0] hc = '0;
      forever begin
         @(negedge clk);
         if (rst_n) begin
            if (held) begin
               check(rect_valid && rect_y == hy && rect_count == hc, "R9",
                     "held rect_y", int'(rect_y), int'(hy));
            end
            if (rect_valid) begin
               check(!line_ready, "R9", "line_ready while pending", int'(line_ready), 0);
            end
            if (in_full) begin
               check(!line_ready, "R7", "line_ready in full update", int'(line_ready), 0);
            end
            held = rect_valid && !rect_ready;
            hy   = rect_y;
            hc   = rect_count;
         end
      end
   end

   task automatic start_frame(input int h, input int w, input bit f);
      frame_height = LW'(h);
      mode_width   = WW'(w);
      full_req     = f;
      frame_start  = 1'b1;
      @(posedge clk);
      #1;
      frame_start = 1'b0;
      full_req    = 1'b0;
   endtask

   task automatic wait_done();
      int n = 0;
      @(negedge clk);
      while (!frame_done && n < 2000) begin
         @(negedge clk);
         n++;
      end
      check(frame_done, "R10", "frame_done seen", int'(frame_done), 1);
      check(exp_q.size() == 0, "R10", "rects left at done", exp_q.size(), 0);
      check(!rect_valid, "R10", "rect_valid at done", int'(rect_valid), 0);
      @(negedge clk);
      check(!frame_done, "R10", "done pulse length", int'(frame_done), 0);
      @(posedge clk);
      #1;
   endtask

   task automatic run_frame(input int h, input int w, input logic [255:0] d,
                            input bit gaps, input bit poke);
      bit open = 1'b0;
      int s = 0;
      for (int i = 0; i < h; i++) begin
         if (d[i] && !open) begin
            open = 1'b1;
            s = i;
         end else if (!d[i] && open) begin
            exp_q.push_back('{y: LW'(s), cnt: LW'(i - s), w: WW'(w)});
            open = 1'b0;
         end
      end
      if (open) exp_q.push_back('{y: LW'(s), cnt: LW'(h - s), w: WW'(w)});
      start_frame(h, w, 1'b0);
      for (int i = 0; i < h; i++) begin
         line_valid = 1'b1;
         line_dirty = d[i];
         do @(negedge clk); while (!line_ready);
         @(posedge clk);
         #1;
         line_valid = 1'b0;
         if (poke && i == h / 2) begin
            // R2: a start during the scan must be ignored
            start_frame(5, w + 1, 1'b1);
         end
         if (gaps && (i % 3 == 1)) begin
            @(posedge clk);
            #1;
         end
      end
      wait_done();
   endtask

   task automatic run_full(input int h, input int w);
      exp_q.push_back('{y: '0, cnt: LW'(h), w: WW'(w)});
      in_full = 1'b1;
      start_frame(h, w, 1'b1);
      wait_done();
      in_full = 1'b0;
   endtask

   initial begin
      logic [255:0] d;
      repeat (4) @(posedge clk);
      #1;
      @(negedge clk);
      check(!rect_valid, "R1", "rect_valid after reset", int'(rect_valid), 0);
      check(!frame_done, "R1", "frame_done after reset", int'(frame_done), 0);
      check(!line_ready, "R1", "line_ready after reset", int'(line_ready), 0);
      rst_n = 1'b1;
      @(posedge clk);
      #1;

      // R3 R4: two runs closed by clean lines
      d = '0; d[2] = 1; d[3] = 1; d[4] = 1; d[7] = 1;
      run_frame(10, 640, d, 1'b0, 1'b0);
      // R5: every line dirty, flushed at the end
      d = '0; d[7:0] = 8'hFF;
      run_frame(8, 800, d, 1'b1, 1'b0);
      // R8: nothing dirty
      d = '0;
      run_frame(8, 800, d, 1'b0, 1'b0);
      // R3 R5: run at line 0 and run reaching the end
      d = '0; d[0] = 1; d[9] = 1; d[10] = 1; d[11] = 1;
      run_frame(12, 1024, d, 1'b1, 1'b0);
      // R4: alternating single lines
      d = '0; d[5:0] = 6'b010101;
      run_frame(6, 320, d, 1'b0, 1'b0);
      // R7: whole-screen request
      run_full(64, 1280);
      // R5: one-line frames
      d = '0; d[0] = 1;
      run_frame(1, 64, d, 1'b0, 1'b0);
      d = '0;
      run_frame(1, 64, d, 1'b0, 1'b0);
      // R11: empty frame
      run_frame(0, 100, d, 1'b0, 1'b0);
      // R9: long pattern under backpressure
      bp_mode = 1'b1;
      d = '0;
      for (int i = 0; i < 150; i++) d[i] = ((i * 7) % 11) < 5;
      run_frame(150, 1920, d, 1'b1, 1'b0);
      // R2: ignored start in the middle of a frame
      d = '0; d[1] = 1; d[2] = 1; d[14] = 1; d[15] = 1;
      run_frame(16, 720, d, 1'b0, 1'b1);
      run_full(32, 720);
      bp_mode = 1'b0;

      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      checks++;
      errors++;
      $display("FAIL R10 watchdog: actual running expected finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule